// File: doc/BRIEF.md
# Interrupt Source Delivery Router

This block keeps the configuration and live state of a bank of interrupt sources and decides, for each source that is ready, which processor targets get it. Each source has a control word (masking, in-service flag, delivery style, input polarity, sense type, priority, vector) and a target word (per-target enables, per-target critical-route bits and an external-pin enable bit). Raw interrupt lines are captured as edge or level events. A scanner visits one source per clock, in index order, and emits a one-cycle raise pulse per chosen target, together with the source index.

Two delivery styles exist. In broadcast style every enabled target is raised. In rotating style one target is raised: the first enabled one after the target that was served last by that source. A source whose enable set holds only its last-served target always goes to that target. For targets that have a critical-route bit, the pulse leaves on a separate critical output when the global critical feature input is high. Priority arbitration per target is not part of this block. A minimal retire input closes the loop for each source.

Top module: `irq_route_top`

## Requirements
- R1: After reset every control word reads 0x80800000 (masked, active-high, edge, priority 0, vector 0). Every target word reads 0, and no raise output is high.
- R2: Control word layout: bit 31 mask, bit 30 in-service, bit 29 rotating style, bit 23 active-high polarity, bit 22 level sense, bits 20:16 priority, bits 7:0 vector, all other bits 0. Target word layout: bit 31 external enable, bit 30 critical route for target 0, bit 29 critical route for target 1, bits 3:0 target enables. `wr_sel`/`rd_sel` = 0 selects the control word and 1 selects the target word.
- R3: With bit 23 at 0 a low line is the asserted state. With bit 23 at 1 a high line is the asserted state.
- R4: A level source is pending while its line is asserted. Once the line is deasserted, its in-service bit reads 0 within two cycles.
- R5: An edge source becomes pending on a deasserted-to-asserted transition. A line held asserted does not make it pending again.
- R6: A source is raised only if it is pending, unmasked, has a nonzero priority, has its in-service bit at 0 and has at least one enabled target. Otherwise no raise occurs.
- R7: A raise sets the in-service bit. A source that is in service is not raised again.
- R8: If the enable set equals exactly the source's last-served target, that target alone is raised, and the last-served target stays the same.
- R9: In broadcast style (bit 29 = 0), every enabled target is raised in the same cycle.
- R10: In rotating style the search starts at the target after the last-served one and wraps at the target count. Exactly the first enabled target is raised, and it becomes the last-served target. The last-served target is 0 after reset.
- R11: When `crit_en` is high and a raised target t < 2 has its critical-route bit set, `raise_crit[t]` pulses instead of `raise_int[t]`. Otherwise `raise_int[t]` pulses.
- R12: A retire (`ack_valid` with `ack_idx`) clears the source's in-service bit. For an edge source it also clears the pending state.
- R13: Sources are scanned one per clock in index order, wrapping after the last one. A raise appears as a one-cycle pulse in the cycle after the source's scan slot, with `raise_src` set to the source index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Raw interrupt lines, one per source |
| crit_en | input | 1 | Enables the critical output route |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 control word, 1 target word |
| wr_idx | input | 5 | Source index for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | 0 control word, 1 target word |
| rd_idx | input | 5 | Source index for the read |
| rd_data | output | 32 | Read data (combinational) |
| ack_valid | input | 1 | Retire strobe |
| ack_idx | input | 5 | Source being retired |
| raise_int | output | 4 | Normal raise pulse per target |
| raise_crit | output | 4 | Critical raise pulse per target |
| raise_src | output | 5 | Index of the source being raised |

## Verification
A corrupted in-service bit shows up in one of two ways within one scan round (32 cycles). A source that should stay silent is raised a second time, or a pending source is never raised. The in-service bit can also be read back directly. A wrong last-served target changes which single target a rotating source hits on its next delivery, so repeated deliveries of one source are compared against a predicted rotation. A wrong pending capture shows as a missing or extra raise for edge lines that are pulsed or held, observed within one scan round of the stimulus.

// File: rtl/irq_route_pkg.sv
// Package: field positions of the register words and the per-source control type.
// Assumes 32-bit register words; bit positions are visible to software.
package irq_route_pkg;
    localparam int REG_W         = 32;
    localparam int PRIO_W        = 5;
    localparam int CFG_MASK_BIT  = 31;
    localparam int CFG_ACT_BIT   = 30;
    localparam int CFG_MODE_BIT  = 29;
    localparam int CFG_POL_BIT   = 23;
    localparam int CFG_SENSE_BIT = 22;
    localparam int CFG_PRIO_LSB  = 16;
    localparam int DST_EXT_BIT   = 31;
    localparam int DST_CRIT_TOP  = 30;

    typedef struct packed {
        logic              masked;
        logic              in_svc;
        logic              rotate;
        logic              act_high;
        logic              lvl;
        logic [PRIO_W-1:0] prio;
    } src_ctl_t;

    typedef enum logic { SEL_CTL = 1'b0, SEL_TGT = 1'b1 } reg_sel_e;
endpackage

// File: rtl/irq_line_capture.sv
// Module: turns raw lines into pending flags, per source.
// Applies polarity first. Level sources copy the asserted state each cycle.
// Edge sources latch a rising asserted state and hold it until retired.
// Assumes the lines are already synchronous to clk.
module irq_line_capture #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [NUM_SRC-1:0] act_high,
    input  logic [NUM_SRC-1:0] lvl,
    input  logic [NUM_SRC-1:0] retire,
    output logic [NUM_SRC-1:0] pend
);
    logic [NUM_SRC-1:0] asserted;
    logic [NUM_SRC-1:0] prev_q;

    // Normalise polarity so that 1 always means asserted.
    assign asserted = irq_in ~^ act_high;

    // Keep the previous asserted state for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= asserted;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        // Per-source pending flag: follow the level, or set on edge / clear on retire.
        always_ff @(posedge clk) begin
            if (!rst_n)                           pend[i] <= 1'b0;
            else if (lvl[i])                      pend[i] <= asserted[i];
            else if (asserted[i] && !prev_q[i])   pend[i] <= 1'b1;
            else if (retire[i])                   pend[i] <= 1'b0;
        end

        assert_level_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
            lvl[i] |=> (pend[i] == $past(asserted[i])));
        assert_edge_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!lvl[i] && asserted[i] && !prev_q[i]) |=> pend[i]);
    end
endmodule

// File: rtl/irq_tgt_select.sv
// Module: picks the targets for one source from its enable set.
// Handles the single-last-target shortcut, broadcast style and rotating style.
// Purely combinational. Assumes NUM_TGT >= 2.
module irq_tgt_select #(
    parameter int NUM_TGT = 4,
    localparam int TW     = $clog2(NUM_TGT)
) (
    input  logic [NUM_TGT-1:0] ena,
    input  logic [TW-1:0]      last,
    input  logic               rotate,
    output logic [NUM_TGT-1:0] tmask,
    output logic [TW-1:0]      new_last,
    output logic               upd_last
);
    logic [NUM_TGT-1:0] last_bit;
    logic [NUM_TGT-1:0] rot_mask;
    logic [TW-1:0]      rot_last;
    logic               found;

    assign last_bit = {{(NUM_TGT-1){1'b0}}, 1'b1} << last;

    // Rotating search: first enabled target after the last one, wrapping around.
    always_comb begin
        rot_mask = '0;
        rot_last = last;
        found    = 1'b0;
        for (int k = 1; k < NUM_TGT; k++) begin
            if (!found && ena[TW'((int'(last) + k) % NUM_TGT)]) begin
                found = 1'b1;
                rot_mask[TW'((int'(last) + k) % NUM_TGT)] = 1'b1;
                rot_last = TW'((int'(last) + k) % NUM_TGT);
            end
        end
    end

    // Choose between the shortcut, broadcast and rotating results.
    always_comb begin
        if (ena == last_bit || !rotate) begin
            tmask    = ena;
            new_last = last;
            upd_last = 1'b0;
        end else begin
            tmask    = rot_mask;
            new_last = rot_last;
            upd_last = found;
        end
    end
endmodule

// File: rtl/irq_route_top.sv
// Module: interrupt source delivery router.
// Holds the per-source control and target words, captures the lines,
// scans one source per clock and emits registered raise pulses per target.
// Assumes a single write port, a combinational read port and at most one
// retire per cycle.
module irq_route_top
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC   = 32,
    parameter int NUM_TGT   = 4,
    parameter int CRIT_TGTS = 2,
    parameter int VEC_W     = 8,
    localparam int SW       = $clog2(NUM_SRC),
    localparam int TW       = $clog2(NUM_TGT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               crit_en,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [SW-1:0]      wr_idx,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               rd_sel,
    input  logic [SW-1:0]      rd_idx,
    output logic [REG_W-1:0]   rd_data,
    input  logic               ack_valid,
    input  logic [SW-1:0]      ack_idx,
    output logic [NUM_TGT-1:0] raise_int,
    output logic [NUM_TGT-1:0] raise_crit,
    output logic [SW-1:0]      raise_src
);
    src_ctl_t             ctl_q   [NUM_SRC];
    logic [VEC_W-1:0]     vec_q   [NUM_SRC];
    logic [NUM_TGT-1:0]   ena_q   [NUM_SRC];
    logic [CRIT_TGTS-1:0] crit_q  [NUM_SRC];
    logic                 ext_q   [NUM_SRC];
    logic [TW-1:0]        last_q  [NUM_SRC];
    logic [SW-1:0]        scan_q;

    logic [NUM_SRC-1:0]   pend, act_high_v, lvl_v, retire_v, in_svc_nxt;
    logic [NUM_TGT-1:0]   tmask, crit_route;
    logic [TW-1:0]        new_last;
    logic                 upd_last, fire;
    logic                 unused_wdata;

    assign unused_wdata = ^wr_data;

    // Gather per-source fields into vectors for the capture stage.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            act_high_v[i] = ctl_q[i].act_high;
            lvl_v[i]      = ctl_q[i].lvl;
            retire_v[i]   = ack_valid && (ack_idx == SW'(i));
        end
    end

    irq_line_capture #(.NUM_SRC(NUM_SRC)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .act_high (act_high_v),
        .lvl      (lvl_v),
        .retire   (retire_v),
        .pend     (pend)
    );

    irq_tgt_select #(.NUM_TGT(NUM_TGT)) u_sel (
        .ena      (ena_q[scan_q]),
        .last     (last_q[scan_q]),
        .rotate   (ctl_q[scan_q].rotate),
        .tmask    (tmask),
        .new_last (new_last),
        .upd_last (upd_last)
    );

    // Eligibility of the source under the scan pointer.
    assign fire = pend[scan_q] && !ctl_q[scan_q].masked && (ctl_q[scan_q].prio != '0)
                  && !ctl_q[scan_q].in_svc && (tmask != '0);

    // Critical routing per target for the scanned source.
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_crit
        if (t < CRIT_TGTS) begin : g_has
            assign crit_route[t] = crit_en && crit_q[scan_q][t];
        end else begin : g_none
            assign crit_route[t] = 1'b0;
        end
    end

    // Scan pointer: one source per clock, wrapping at the source count.
    always_ff @(posedge clk) begin
        if (!rst_n)                            scan_q <= '0;
        else if (scan_q == SW'(NUM_SRC - 1))   scan_q <= '0;
        else                                   scan_q <= scan_q + 1'b1;
    end

    // Registered raise pulses toward the targets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raise_int  <= '0;
            raise_crit <= '0;
            raise_src  <= '0;
        end else begin
            raise_int  <= fire ? (tmask & ~crit_route) : '0;
            raise_crit <= fire ? (tmask & crit_route)  : '0;
            raise_src  <= fire ? scan_q : '0;
        end
    end

    // Next in-service state: set by delivery, cleared by level drop, then by retire.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            in_svc_nxt[i] = ctl_q[i].in_svc;
            if (fire && scan_q == SW'(i))      in_svc_nxt[i] = 1'b1;
            if (ctl_q[i].lvl && !pend[i])      in_svc_nxt[i] = 1'b0;
            if (retire_v[i])                   in_svc_nxt[i] = 1'b0;
        end
    end

    // Control word storage with write port and in-service update.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_SRC; i++) begin
            if (!rst_n) begin
                ctl_q[i] <= '{masked: 1'b1, in_svc: 1'b0, rotate: 1'b0,
                              act_high: 1'b1, lvl: 1'b0, prio: '0};
                vec_q[i] <= '0;
            end else if (wr_en && reg_sel_e'(wr_sel) == SEL_CTL && wr_idx == SW'(i)) begin
                ctl_q[i].masked   <= wr_data[CFG_MASK_BIT];
                ctl_q[i].in_svc   <= wr_data[CFG_ACT_BIT];
                ctl_q[i].rotate   <= wr_data[CFG_MODE_BIT];
                ctl_q[i].act_high <= wr_data[CFG_POL_BIT];
                ctl_q[i].lvl      <= wr_data[CFG_SENSE_BIT];
                ctl_q[i].prio     <= wr_data[CFG_PRIO_LSB +: PRIO_W];
                vec_q[i]          <= wr_data[VEC_W-1:0];
            end else begin
                ctl_q[i].in_svc   <= in_svc_nxt[i];
            end
        end
    end

    // Target word storage and last-served target tracking.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_SRC; i++) begin
            if (!rst_n) begin
                ena_q[i]  <= '0;
                crit_q[i] <= '0;
                ext_q[i]  <= 1'b0;
                last_q[i] <= '0;
            end else begin
                if (wr_en && reg_sel_e'(wr_sel) == SEL_TGT && wr_idx == SW'(i)) begin
                    ena_q[i] <= wr_data[NUM_TGT-1:0];
                    ext_q[i] <= wr_data[DST_EXT_BIT];
                    for (int t = 0; t < CRIT_TGTS; t++) crit_q[i][t] <= wr_data[DST_CRIT_TOP - t];
                end
                if (fire && upd_last && scan_q == SW'(i)) last_q[i] <= new_last;
            end
        end
    end

    // Read mux assembling the selected register word.
    always_comb begin
        rd_data = '0;
        if (reg_sel_e'(rd_sel) == SEL_CTL) begin
            rd_data[CFG_MASK_BIT]               = ctl_q[rd_idx].masked;
            rd_data[CFG_ACT_BIT]                = ctl_q[rd_idx].in_svc;
            rd_data[CFG_MODE_BIT]               = ctl_q[rd_idx].rotate;
            rd_data[CFG_POL_BIT]                = ctl_q[rd_idx].act_high;
            rd_data[CFG_SENSE_BIT]              = ctl_q[rd_idx].lvl;
            rd_data[CFG_PRIO_LSB +: PRIO_W]     = ctl_q[rd_idx].prio;
            rd_data[VEC_W-1:0]                  = vec_q[rd_idx];
        end else begin
            rd_data[DST_EXT_BIT]                = ext_q[rd_idx];
            for (int t = 0; t < CRIT_TGTS; t++) rd_data[DST_CRIT_TOP - t] = crit_q[rd_idx][t];
            rd_data[NUM_TGT-1:0]                = ena_q[rd_idx];
        end
    end

    assert_fire_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (((raise_int | raise_crit) != '0) && raise_src == $past(scan_q)));
    assert_scan_wrap_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_q == SW'(NUM_SRC - 1)) |=> (scan_q == '0));
    assert_rotate_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && ctl_q[scan_q].rotate) |-> $onehot(tmask));
    assert_crit_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_crit != '0) |-> $past(crit_en));
    assert_no_dual_route_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_int & raise_crit) == '0);
endmodule

// File: tb/irq_route_top_tb.sv
module irq_route_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        crit_en = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0, ack_valid = 1'b0;
    logic [4:0]  wr_idx = '0, rd_idx = '0, ack_idx = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  raise_int, raise_crit;
    logic [4:0]  raise_src;

    int nchk = 0, nerr = 0;
    int seen = 0;
    logic [3:0] seen_int, seen_crit;
    logic [4:0] seen_src;

    always #2 clk = ~clk;

    irq_route_top u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .crit_en(crit_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data),
        .ack_valid(ack_valid), .ack_idx(ack_idx),
        .raise_int(raise_int), .raise_crit(raise_crit), .raise_src(raise_src)
    );

    // Vector fields: [77:73] source, [72:41] control word, [40:9] target word,
    // [8] crit_en, [7:4] expected normal mask, [3:0] expected critical mask.
    localparam logic [77:0] VTBL [15] = '{
        {5'd3,  32'h00C50003, 32'h00000005, 1'b0, 4'b0101, 4'b0000}, // R9
        {5'd5,  32'h00C50005, 32'h4000000F, 1'b1, 4'b1110, 4'b0001}, // R9 R11
        {5'd7,  32'h20C50007, 32'h00000006, 1'b0, 4'b0010, 4'b0000}, // R10
        {5'd7,  32'h20C50007, 32'h00000006, 1'b0, 4'b0100, 4'b0000}, // R10
        {5'd7,  32'h20C50007, 32'h00000006, 1'b0, 4'b0010, 4'b0000}, // R10 wrap
        {5'd9,  32'h20C50009, 32'h00000001, 1'b0, 4'b0001, 4'b0000}, // R8
        {5'd10, 32'h80C5000A, 32'h0000000F, 1'b0, 4'b0000, 4'b0000}, // R6 masked
        {5'd11, 32'h00C0000B, 32'h0000000F, 1'b0, 4'b0000, 4'b0000}, // R6 prio 0
        {5'd12, 32'h00C5000C, 32'h00000000, 1'b0, 4'b0000, 4'b0000}, // R6 no target
        {5'd2,  32'h00C50002, 32'h20000002, 1'b0, 4'b0010, 4'b0000}, // R11 off
        {5'd2,  32'h00C50002, 32'h20000002, 1'b1, 4'b0000, 4'b0010}, // R11 on
        {5'd31, 32'h0045001F, 32'h00000008, 1'b0, 4'b1000, 4'b0000}, // R3 low active
        {5'd20, 32'h20C50014, 32'h0000000C, 1'b0, 4'b0100, 4'b0000}, // R10
        {5'd20, 32'h20C50014, 32'h00000004, 1'b0, 4'b0100, 4'b0000}, // R8 keeps last
        {5'd20, 32'h20C50014, 32'h0000000C, 1'b0, 4'b1000, 4'b0000}  // R8 R10
    };

    // Record raise pulses between edges.
    always @(negedge clk) begin
        if (rst_n && (raise_int != '0 || raise_crit != '0)) begin
            seen++;
            seen_int  = raise_int;
            seen_crit = raise_crit;
            seen_src  = raise_src;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic sel, input int idx, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_idx = 5'(idx); wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rreg(input logic sel, input int idx, output logic [31:0] d);
        rd_sel = sel; rd_idx = 5'(idx); #1;
        d = rd_data;
    endtask

    task automatic retire(input int idx);
        @(posedge clk); #1;
        ack_valid = 1'b1; ack_idx = 5'(idx);
        @(posedge clk); #1;
        ack_valid = 1'b0;
    endtask

    task automatic wait_scan();
        repeat (96) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(posedge clk); #1;
        // R1: reset state
        rreg(1'b0, 0, d);  chk("R1 ctl reset", d, 32'h80800000);
        rreg(1'b1, 17, d); chk("R1 tgt reset", d, 32'h0);
        chk("R1 raise idle", {28'h0, raise_int | raise_crit}, 32'h0);
        rst_n = 1'b1;
        // R2: register layout
        wreg(1'b0, 30, 32'hBFFFFFFF);
        rreg(1'b0, 30, d); chk("R2 ctl layout", d, 32'hA0DF00FF);
        wreg(1'b1, 30, 32'hFFFFFFFF);
        rreg(1'b1, 30, d); chk("R2 tgt layout", d, 32'hE000000F);

        // Vector table walk
        foreach (VTBL[v]) begin
            int s; logic hi;
            s  = int'(VTBL[v][77:73]);
            hi = VTBL[v][72-8];           // polarity bit 23 of the control word
            irq_in[s] = ~hi;
            repeat (2) @(posedge clk); #1;
            wreg(1'b1, s, VTBL[v][40:9]);
            wreg(1'b0, s, VTBL[v][72:41]);
            crit_en = VTBL[v][8];
            repeat (2) @(posedge clk); #1;
            seen = 0; seen_int = '0; seen_crit = '0; seen_src = '0;
            irq_in[s] = hi;
            wait_scan();
            chk($sformatf("R6/R7/R13 vec%0d raise count", v), seen,
                (VTBL[v][7:0] != 0) ? 1 : 0);
            chk($sformatf("R8/R9/R10 vec%0d normal mask", v), {28'h0, seen_int}, {28'h0, VTBL[v][7:4]});
            chk($sformatf("R11 vec%0d critical mask", v), {28'h0, seen_crit}, {28'h0, VTBL[v][3:0]});
            if (VTBL[v][7:0] != 0) chk($sformatf("R13 vec%0d source", v), {27'h0, seen_src}, s);
            irq_in[s] = ~hi;
            repeat (3) @(posedge clk); #1;
            retire(s);
            crit_en = 1'b0;
        end

        // Edge source: R5 R7 R12
        wreg(1'b1, 4, 32'h00000001);
        wreg(1'b0, 4, 32'h00850004);
        seen = 0;
        @(posedge clk); #1; irq_in[4] = 1'b1;
        @(posedge clk); #1; irq_in[4] = 1'b0;
        wait_scan();
        chk("R5 edge pulse raises once", seen, 1);
        rreg(1'b0, 4, d); chk("R7 in-service set", d, 32'h40850004);
        seen = 0;
        @(posedge clk); #1; irq_in[4] = 1'b1;
        @(posedge clk); #1; irq_in[4] = 1'b0;
        wait_scan();
        chk("R7 no raise while in service", seen, 0);
        retire(4);
        seen = 0;
        wait_scan();
        chk("R12 edge retire drops pending", seen, 0);
        rreg(1'b0, 4, d); chk("R12 in-service cleared", d, 32'h00850004);
        @(posedge clk); #1; irq_in[4] = 1'b1;
        wait_scan();
        chk("R5 new edge raises", seen, 1);
        retire(4);
        seen = 0;
        wait_scan();
        chk("R5 held line no re-pend", seen, 0);
        irq_in[4] = 1'b0;

        // Level source: R4 R12
        wreg(1'b1, 6, 32'h00000002);
        wreg(1'b0, 6, 32'h00C50006);
        seen = 0;
        @(posedge clk); #1; irq_in[6] = 1'b1;
        wait_scan();
        chk("R4 level raises once", seen, 1);
        rreg(1'b0, 6, d); chk("R7 level in service", d, 32'h40C50006);
        retire(6);
        seen = 0;
        wait_scan();
        chk("R12 level retire re-raises", seen, 1);
        @(posedge clk); #1; irq_in[6] = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        rreg(1'b0, 6, d); chk("R4 low level clears in-service", d, 32'h00C50006);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule